// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

A watchdog timer for a system chip. Software arms it by writing a control word that carries a start count, a run bit and a seven-bit key. Once armed, the counter drops by one on every slow tick. The tick comes from a prescaler on the core clock, and its default divide gives about 760 ticks per second at 200 MHz.

The first expiry raises a non-maskable interrupt and reloads the counter with a short grace count. Software is expected to service the watchdog inside that grace window. If the grace count also runs out, the block raises a sticky system reset request for an external reset generator.

While the watchdog runs, the control word is write-protected. A write is taken only if its key is the bitwise complement of the key held from the previous accepted write, so the key must alternate on every service. A status word makes the live count and the expiry state visible.

Top module: `keyed_watchdog`

## Requirements
- R1: After rst_ni is asserted, nmi_o and rst_req_o are 0, the control word reads 0 and the status word reads 0 (counter stopped at zero).
- R2: While bit 8 of the stored control word is 0, a write of wr_data_i to offset 0x40 is accepted whatever its key, and offset 0x40 reads back the written value from the next cycle.
- R3: While bit 8 of the stored control word is 1, a write to offset 0x40 whose bits [15:9] differ from the bitwise complement of the stored bits [15:9] is ignored. The control word, the count, the run state, the grace state and nmi_o are all left as they are.
- R4: An accepted write with bit 8 set loads the counter with bits [8:0] of the write and starts it. An accepted write with bit 8 clear stops the counter, and the count holds its value.
- R5: While the counter runs, it decrements once every TICK_DIV clocks. The first tick comes TICK_DIV clocks after the accepted start write.
- R6: A tick that arrives while the count is 0 or 1 is an expiry. The first expiry sets nmi_o, loads the counter with GRACE_CNT and enters the grace stage.
- R7: An expiry in the grace stage sets rst_req_o and stops the counter at zero. rst_req_o stays set until rst_ni.
- R8: An accepted write clears nmi_o and leaves the grace stage, so the next expiry again counts as a first expiry.
- R9: Offset 0x44 reads status: bits [8:0] the count, bit 9 running, bit 10 grace stage, bit 11 nmi_o, bit 12 rst_req_o, with the upper bits 0. Reads are combinational, and any other offset reads 0.
- R10: Writes to any offset other than 0x40 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write byte offset |
| wr_data_i | input | CNT_W+KEY_W | Write data |
| rd_addr_i | input | ADDR_W | Read byte offset |
| rd_data_o | output | CNT_W+KEY_W | Read data, combinational |
| nmi_o | output | 1 | Non-maskable interrupt, first expiry |
| rst_req_o | output | 1 | System reset request, second expiry |

## Verification
A wrong key decision shows at the control readback on the cycle after the write. A wrong load, a wrong prescale phase or a wrong decrement shows in the status count within one tick period. A wrong stage shows as nmi_o or rst_req_o at the wrong moment: too early, too late, or when the grace window ends. The bench compares every status and control bit against a behavioural model on every clock, so each of these faults appears within TICK_DIV cycles of its cause.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic {
    STG_ARMED = 1'b0,
    STG_GRACE = 1'b1
  } wdg_stage_e;
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate #(
  parameter int CNT_W = 9,
  parameter int KEY_W = 7,
  localparam int CTRL_W = CNT_W + KEY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              accept_o
);
  localparam int EN_BIT = CNT_W - 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic              locked;
  logic              key_match;

  assign locked    = ctrl_q[EN_BIT];
  assign key_match = (wdata_i[CTRL_W-1:CNT_W] == ~ctrl_q[CTRL_W-1:CNT_W]);
  assign accept_o  = wr_i && (!locked || key_match);
  assign ctrl_o    = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (accept_o) ctrl_q <= wdata_i;
  end

  p_locked_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ctrl_q[EN_BIT] &&
     (wdata_i[CTRL_W-1:CNT_W] != ~ctrl_q[CTRL_W-1:CNT_W])) |=> $stable(ctrl_q));

  p_open_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ctrl_q[EN_BIT]) |=> (ctrl_q == $past(wdata_i)));
endmodule

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter int TICK_DIV = 263158
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int PRE_W = $clog2(TICK_DIV);
      logic [PRE_W-1:0] pre_q;
      logic             wrap;

      assign wrap   = (pre_q == PRE_W'(TICK_DIV - 1));
      assign tick_o = run_i && wrap;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       pre_q <= '0;
        else if (restart_i || !run_i || wrap) pre_q <= '0;
        else                               pre_q <= pre_q + 1'b1;
      end

      p_tick_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end else begin : g_nodiv
      assign tick_o = run_i;
    end
  endgenerate
endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter
  import wdg_pkg::*;
#(
  parameter int CNT_W     = 9,
  parameter int GRACE_CNT = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output wdg_stage_e       stage_o,
  output logic             nmi_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] GRACE_V = CNT_W'(GRACE_CNT);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, nmi_q, rst_q;
  wdg_stage_e       stage_q;
  logic             expire;

  assign expire = run_q && tick_i && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      nmi_q   <= 1'b0;
      rst_q   <= 1'b0;
      stage_q <= STG_ARMED;
    end else if (load_i) begin
      nmi_q   <= 1'b0;
      stage_q <= STG_ARMED;
      run_q   <= start_i;
      if (start_i) cnt_q <= load_val_i;
    end else if (expire) begin
      if (stage_q == STG_ARMED) begin
        cnt_q   <= GRACE_V;
        nmi_q   <= 1'b1;
        stage_q <= STG_GRACE;
      end else begin
        cnt_q <= '0;
        run_q <= 1'b0;
        rst_q <= 1'b1;
      end
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign run_o     = run_q;
  assign stage_o   = stage_q;
  assign nmi_o     = nmi_q;
  assign rst_req_o = rst_q;

  p_start_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && start_i) |=> (run_o && cnt_o == $past(load_val_i)));
  p_stop_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !start_i) |=> (!run_o && $stable(cnt_o)));
  p_nmi_grace_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) |-> (stage_o == STG_GRACE && cnt_o == GRACE_V));
  p_rst_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);
  p_rst_after_grace_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> ($past(stage_o) == STG_GRACE && !run_o));
  p_write_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!nmi_o && stage_o == STG_ARMED));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int          CNT_W     = 9,
  parameter int          KEY_W     = 7,
  parameter int          GRACE_CNT = 10,
  parameter int          TICK_DIV  = 263158,
  parameter int          ADDR_W    = 8,
  parameter int unsigned CTRL_OFFS = 32'h40,
  parameter int unsigned STAT_OFFS = 32'h44,
  localparam int         DATA_W    = CNT_W + KEY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              nmi_o,
  output logic              rst_req_o
);
  localparam int EN_BIT = CNT_W - 1;
  localparam int STAT_W = CNT_W + 4;

  logic              wr_ctrl, accept, tick, run;
  logic [DATA_W-1:0] ctrl;
  logic [CNT_W-1:0]  cnt;
  wdg_stage_e        stage;
  logic [STAT_W-1:0] stat;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_OFFS));

  wdg_key_gate #(.CNT_W(CNT_W), .KEY_W(KEY_W)) u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ctrl),
    .wdata_i (wr_data_i),
    .ctrl_o  (ctrl),
    .accept_o(accept)
  );

  wdg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .restart_i(accept),
    .tick_o   (tick)
  );

  wdg_down_counter #(.CNT_W(CNT_W), .GRACE_CNT(GRACE_CNT)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .start_i   (wr_data_i[EN_BIT]),
    .load_val_i(wr_data_i[CNT_W-1:0]),
    .tick_i    (tick),
    .cnt_o     (cnt),
    .run_o     (run),
    .stage_o   (stage),
    .nmi_o     (nmi_o),
    .rst_req_o (rst_req_o)
  );

  assign stat = {rst_req_o, nmi_o, (stage == STG_GRACE), run, cnt};

  always_comb begin
    if (rd_addr_i == ADDR_W'(CTRL_OFFS))      rd_data_o = ctrl;
    else if (rd_addr_i == ADDR_W'(STAT_OFFS)) rd_data_o = DATA_W'(stat);
    else                                      rd_data_o = '0;
  end

  p_other_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_ctrl) |=> $stable(ctrl));
  p_nmi_not_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> (stage == STG_GRACE || rst_req_o));
endmodule

// File: tb/keyed_watchdog_tb.sv
`timescale 1ns/1ps
module keyed_watchdog_tb;
  localparam int TDIV  = 4;
  localparam int GRACE = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_addr = 8'h44;
  logic [15:0] rd_data;
  logic        nmi, rst_req;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  keyed_watchdog #(.TICK_DIV(TDIV), .GRACE_CNT(GRACE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .nmi_o(nmi), .rst_req_o(rst_req)
  );

  // behavioural reference
  logic [15:0] m_ctrl;
  int m_cnt, m_pre;
  bit m_run, m_grace, m_nmi, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_cnt = 0; m_pre = 0;
      m_run = 0; m_grace = 0; m_nmi = 0; m_rst = 0;
    end else if (wr_en && wr_addr == 8'h40 &&
                 (!m_ctrl[8] || wr_data[15:9] == (~m_ctrl[15:9]))) begin
      m_ctrl = wr_data; m_nmi = 0; m_grace = 0; m_pre = 0;
      m_run = wr_data[8];
      if (wr_data[8]) m_cnt = int'(wr_data[8:0]);
    end else if (m_run) begin
      if (m_pre == TDIV - 1) begin
        m_pre = 0;
        if (m_cnt <= 1) begin
          if (!m_grace) begin
            m_cnt = GRACE; m_nmi = 1; m_grace = 1;
          end else begin
            m_cnt = 0; m_run = 0; m_rst = 1;
          end
        end else m_cnt = m_cnt - 1;
      end else m_pre = m_pre + 1;
    end
  end

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // per-cycle compare, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    chk("nmi_o", {15'd0, nmi}, {15'd0, m_nmi});
    chk("rst_req_o", {15'd0, rst_req}, {15'd0, m_rst});
    rd_addr = 8'h44; #0.2;
    chk("status", rd_data, {3'b0, m_rst, m_nmi, m_grace, m_run, 9'(m_cnt)});
    rd_addr = 8'h40; #0.2;
    chk("control", rd_data, m_ctrl);
    rd_addr = 8'h10; #0.2;
    chk("R9 unmapped read", rd_data, 16'h0);
  end

  function automatic logic [15:0] mk(logic [6:0] key, logic en, logic [7:0] c);
    return {key, en, c};
  endfunction

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_nmi(int lim);
    for (int i = 0; i < lim && !nmi; i++) @(negedge clk);
  endtask

  task automatic wait_rst(int lim);
    for (int i = 0; i < lim && !rst_req; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout act=running exp=done");
    finish_run();
  end

  initial begin
    idle(3);
    tag = "R1"; rst_n = 1'b1; idle(3);
    tag = "R2"; wr(8'h40, mk(7'h55, 1'b0, 8'hA5)); idle(3);
    tag = "R4"; wr(8'h40, mk(7'h2A, 1'b1, 8'h03)); idle(20);
    tag = "R3"; wr(8'h40, mk(7'h2A, 1'b1, 8'h50)); idle(3);
    wr(8'h40, mk(7'h00, 1'b0, 8'h00)); idle(3);
    tag = "R8"; wr(8'h40, mk(7'h55, 1'b1, 8'h02));
    tag = "R5"; idle(40);
    tag = "R6"; wait_nmi(3000); idle(12);
    chk("R6 nmi raised", {15'd0, nmi}, 16'd1);
    tag = "R8"; wr(8'h40, mk(7'h2A, 1'b1, 8'h00)); idle(3);
    chk("R8 nmi cleared", {15'd0, nmi}, 16'd0);
    tag = "R7"; wait_rst(5000); idle(10);
    chk("R7 reset request", {15'd0, rst_req}, 16'd1);
    wr(8'h40, mk(7'h55, 1'b0, 8'h00)); idle(10);
    chk("R7 sticky", {15'd0, rst_req}, 16'd1);
    tag = "R10"; wr(8'h10, 16'hFFFF); wr(8'h44, 16'hFFFF); idle(5);
    tag = "R2"; wr(8'h40, mk(7'h11, 1'b1, 8'h40)); idle(30);
    tag = "R1"; @(negedge clk); rst_n = 1'b0; idle(2);
    chk("R1 nmi in reset", {15'd0, nmi}, 16'd0);
    chk("R1 rst_req in reset", {15'd0, rst_req}, 16'd0);
    rst_n = 1'b1; idle(5);
    finish_run();
  end
endmodule